// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Idle Parking

This block decides which of up to eight bus masters may start an address tenure. Each master raises its own request line, and the arbiter answers with a one-hot grant vector. A master keeps its grant until it pulses the tenure-done strobe. When several masters ask at once, the winner comes from a rotating priority order. That order starts at the master after the one granted most recently.

When nobody is requesting, a configurable parking policy decides who holds the bus. The bus can be left ungranted, parked on the last master that used it, or parked on a master chosen by index. A parked master that raises its request gets the bus without waiting for an arbitration cycle.

A pipelining-disable setting chooses between two modes. In the first, the arbiter waits for the data phase of the previous transfer to finish before it grants again. In the second, the next address grant can overlap that data phase. The three settings are captured from configuration inputs on a write strobe.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset the grant vector is all zeros. The captured configuration is pipelining disabled (1), parking mode 2'b00 and select index 0. When `cfg_we_i` is high at a clock edge, `pipe_dis_i`, `park_mode_i` and `park_sel_i` are loaded, and they govern arbitration from the following edge onward.
- R2: When the bus is free and at least one master requests, exactly one bit of `gnt_o` rises one clock after the request is sampled. Bit i of `gnt_o` grants master i.
- R3: Among simultaneous requesters, the first one found while searching upward (wrapping) from the master after the last one granted wins. After reset the search starts at master 0.
- R4: A granted master keeps its grant unchanged until `tenure_done_i` is sampled high. The grant drops at the next edge.
- R5: Parking modes 2'b00 and the reserved 2'b01 park nobody: with no requests on a free bus, `gnt_o` becomes all zeros.
- R6: Parking mode 2'b10 parks the idle bus on the master granted most recently. Before any master has been granted since reset, nobody is parked.
- R7: Parking mode 2'b11 parks the idle bus on the master whose index is `park_sel_i` as captured.
- R8: A parked master that requests becomes the owner at once, ahead of any rotating-priority winner. Its grant stays asserted with no gap, and a `tenure_done_i` in that same cycle ends its tenure.
- R9: With pipelining disabled, once a tenure ends no grant of any kind is given (parked grants included) until `data_done_i` is sampled high. The next grant appears one clock after that.
- R10: With pipelining enabled, a new grant is issued the clock after a released grant drops, even while the previous data phase is still outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master bus request |
| tenure_done_i | input | 1 | Strobe: the current owner's address tenure is over |
| data_done_i | input | 1 | Strobe: the outstanding data phase has completed |
| cfg_we_i | input | 1 | Load strobe for the three configuration inputs |
| pipe_dis_i | input | 1 | 1 = wait for data completion before granting again |
| park_mode_i | input | 2 | Idle policy: 00/01 none, 10 last master, 11 selected master |
| park_sel_i | input | IDX_W | Master index used by parking mode 11 |
| gnt_o | output | N_MASTERS | One-hot grant |

## Verification
The assertions check four things on every cycle. The grant is at most one-hot, and a held grant stays stable until tenure end. No grant appears while pipelining is disabled and a data phase is pending. The idle grant matches the no-park and programmed-park policies. The rotating priority order, park-on-last (including the no-history case after reset), the zero-latency takeover by a parked master, the overlapped grant in pipelined mode and the one-cycle delay of configuration loads all depend on what happened earlier in a sequence, so only the bench's scenarios show them.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    // Idle-bus policy encodings; the values are decoded by the park selector.
    typedef enum logic [1:0] {
        PARK_NONE = 2'b00,
        PARK_RSVD = 2'b01,
        PARK_LAST = 2'b10,
        PARK_PROG = 2'b11
    } park_mode_e;

endpackage

// File: rtl/bpa_rr_pick.sv
module bpa_rr_pick #(
    parameter int N_MASTERS = 8,
    localparam int IDX_W = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [IDX_W-1:0]     last_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     win_o
);

    logic [31:0] idx;

    // Walk from farthest to nearest so the nearest requester after last_i wins.
    always_comb begin
        any_o = |req_i;
        win_o = '0;
        idx   = '0;
        for (int k = N_MASTERS; k >= 1; k--) begin
            idx = (32'(last_i) + 32'(k)) % 32'(N_MASTERS);
            if (req_i[idx[IDX_W-1:0]]) begin
                win_o = idx[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bpa_park_sel.sv
module bpa_park_sel
    import bpa_pkg::*;
#(
    parameter int N_MASTERS = 8,
    localparam int IDX_W = $clog2(N_MASTERS)
) (
    input  park_mode_e       mode_i,
    input  logic [IDX_W-1:0] sel_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic             hist_i,
    output logic             park_en_o,
    output logic [IDX_W-1:0] park_idx_o
);

    always_comb begin
        park_en_o  = 1'b0;
        park_idx_o = '0;
        unique case (mode_i)
            PARK_LAST: begin
                park_en_o  = hist_i;
                park_idx_o = last_i;
            end
            PARK_PROG: begin
                park_en_o  = (32'(sel_i) < 32'(N_MASTERS));
                park_idx_o = sel_i;
            end
            default: begin
                park_en_o  = 1'b0;
                park_idx_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/bpa_gnt_decode.sv
module bpa_gnt_decode #(
    parameter int N_MASTERS = 8,
    localparam int IDX_W = $clog2(N_MASTERS)
) (
    input  logic                 valid_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [N_MASTERS-1:0] gnt_o
);

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_bit
        assign gnt_o[g] = valid_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import bpa_pkg::*;
#(
    parameter int N_MASTERS = 8,
    localparam int IDX_W = $clog2(N_MASTERS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 tenure_done_i,
    input  logic                 data_done_i,
    input  logic                 cfg_we_i,
    input  logic                 pipe_dis_i,
    input  logic [1:0]           park_mode_i,
    input  logic [IDX_W-1:0]     park_sel_i,
    output logic [N_MASTERS-1:0] gnt_o
);

    localparam logic [N_MASTERS-1:0] ONE_HOT0 = N_MASTERS'(1);

    typedef struct packed {
        logic             own;    // a real tenure is in progress
        logic             park;   // bus parked, no tenure yet
        logic             pend;   // a data phase is outstanding
        logic             hist;   // some master was granted since reset
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] last;
    } arb_state_t;

    typedef struct packed {
        logic             pipe_dis;
        park_mode_e       mode;
        logic [IDX_W-1:0] sel;
    } arb_cfg_t;

    arb_state_t st_d, st_q;
    arb_cfg_t   cfg_d, cfg_q;

    logic             rr_any;
    logic [IDX_W-1:0] rr_win;
    logic             park_en;
    logic [IDX_W-1:0] park_idx;
    logic             bus_free;
    logic             park_hit;

    bpa_rr_pick #(.N_MASTERS(N_MASTERS)) u_rr (
        .req_i  (req_i),
        .last_i (st_q.last),
        .any_o  (rr_any),
        .win_o  (rr_win)
    );

    bpa_park_sel #(.N_MASTERS(N_MASTERS)) u_park (
        .mode_i     (cfg_q.mode),
        .sel_i      (cfg_q.sel),
        .last_i     (st_q.last),
        .hist_i     (st_q.hist),
        .park_en_o  (park_en),
        .park_idx_o (park_idx)
    );

    bpa_gnt_decode #(.N_MASTERS(N_MASTERS)) u_dec (
        .valid_i (st_q.own || st_q.park),
        .idx_i   (st_q.owner),
        .gnt_o   (gnt_o)
    );

    always_comb begin
        st_d  = st_q;
        cfg_d = cfg_q;

        if (cfg_we_i) begin
            cfg_d.pipe_dis = pipe_dis_i;
            cfg_d.mode     = park_mode_e'(park_mode_i);
            cfg_d.sel      = park_sel_i;
        end

        bus_free  = !st_q.own && (!cfg_q.pipe_dis || !st_q.pend || data_done_i);
        park_hit  = st_q.park && req_i[st_q.owner];
        st_d.pend = st_q.pend && !data_done_i;

        if (st_q.own) begin
            if (tenure_done_i) begin
                st_d.own  = 1'b0;
                st_d.pend = 1'b1;
            end
        end else if (bus_free) begin
            st_d.park = 1'b0;
            if (park_hit) begin
                // Parked owner takes the bus in place, no arbitration cycle.
                st_d.own  = !tenure_done_i;
                st_d.last = st_q.owner;
                st_d.hist = 1'b1;
                if (tenure_done_i) begin
                    st_d.pend = 1'b1;
                end
            end else if (rr_any) begin
                st_d.own   = 1'b1;
                st_d.owner = rr_win;
                st_d.last  = rr_win;
                st_d.hist  = 1'b1;
            end else if (park_en) begin
                st_d.park  = 1'b1;
                st_d.owner = park_idx;
            end
        end else begin
            st_d.park = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.own      <= 1'b0;
            st_q.park     <= 1'b0;
            st_q.pend     <= 1'b0;
            st_q.hist     <= 1'b0;
            st_q.owner    <= '0;
            st_q.last     <= IDX_W'(N_MASTERS - 1);
            cfg_q.pipe_dis <= 1'b1;
            cfg_q.mode     <= PARK_NONE;
            cfg_q.sel      <= '0;
        end else begin
            st_q  <= st_d;
            cfg_q <= cfg_d;
        end
    end

    // R2: at most one master holds a grant.
    assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    // R4: a tenure grant is held unchanged until tenure end.
    assert_grant_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.own && !tenure_done_i) |=> ($stable(gnt_o) && (|gnt_o)));

    // R9: no grant while a data phase is pending with pipelining off.
    assert_pipe_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.pipe_dis && st_q.pend && !st_q.own && !data_done_i) |=> (gnt_o == '0));

    // R5: no-park modes leave an idle bus ungranted.
    assert_no_park_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cfg_q.mode == PARK_NONE || cfg_q.mode == PARK_RSVD) && req_i == '0 && !st_q.own)
        |=> (gnt_o == '0));

    // R7: programmed parking grants the selected master on a free idle bus.
    assert_prog_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.mode == PARK_PROG && req_i == '0 && !st_q.own &&
         (!cfg_q.pipe_dis || !st_q.pend || data_done_i) &&
         (32'(cfg_q.sel) < 32'(N_MASTERS)))
        |=> (gnt_o == (ONE_HOT0 << $past(cfg_q.sel))));

endmodule

// File: tb/bus_park_arbiter_tb.sv
`timescale 1ns/100ps
module bus_park_arbiter_tb_top;

    localparam int N = 8;
    localparam int IW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         td = 1'b0;
    logic         dd = 1'b0;
    logic         cfg_we = 1'b0;
    logic         pipe_dis = 1'b1;
    logic [1:0]   pmode = 2'b00;
    logic [IW-1:0] psel = '0;
    logic [N-1:0] gnt;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_park_arbiter #(.N_MASTERS(N)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .req_i         (req),
        .tenure_done_i (td),
        .data_done_i   (dd),
        .cfg_we_i      (cfg_we),
        .pipe_dis_i    (pipe_dis),
        .park_mode_i   (pmode),
        .park_sel_i    (psel),
        .gnt_o         (gnt)
    );

    // Row layout: {req[7:0], tenure_done, data_done, expected grant[7:0]}.
    // Default configuration: pipelining disabled, no parking.
    localparam int NROWS = 13;
    localparam logic [17:0] VEC [NROWS] = '{
        {8'h00, 2'b00, 8'h00},  // R5 idle, nobody parked
        {8'h06, 2'b00, 8'h02},  // R3 first after reset from 0: master 1
        {8'h06, 2'b10, 8'h00},  // R4 tenure ends
        {8'h06, 2'b00, 8'h00},  // R9 data pending blocks grant
        {8'h06, 2'b01, 8'h04},  // R9 data done -> grant, R3 rotates to 2
        {8'h05, 2'b10, 8'h00},  // R4 release
        {8'h05, 2'b01, 8'h01},  // R3 wrap from 2 to 0
        {8'h05, 2'b00, 8'h01},  // R4 hold
        {8'h05, 2'b10, 8'h00},  // R4 release
        {8'h05, 2'b01, 8'h04},  // R3 from 0 to 2
        {8'h00, 2'b10, 8'h00},  // R4 release
        {8'h00, 2'b01, 8'h00},  // R5 idle after data
        {8'h00, 2'b00, 8'h00}   // R5 idle
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] r, input logic t, input logic d);
        req = r;
        td  = t;
        dd  = d;
    endtask

    task automatic cfg_write(input logic pd, input logic [1:0] m, input logic [IW-1:0] s);
        cfg_we   = 1'b1;
        pipe_dis = pd;
        pmode    = m;
        psel     = s;
        step();
        cfg_we   = 1'b0;
    endtask

    task automatic do_reset();
        drive('0, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        check("R1 reset grant", gnt, 8'h00);

        for (int i = 0; i < NROWS; i++) begin
            drive(VEC[i][17:10], VEC[i][9], VEC[i][8]);
            step();
            check($sformatf("R2 table row %0d", i), gnt, VEC[i][7:0]);
        end
        drive('0, 1'b0, 1'b0);

        // R10: pipelined grant overlaps the outstanding data phase.
        cfg_write(1'b0, 2'b00, '0);
        drive(8'h08, 1'b0, 1'b0);
        step();
        check("R2 grant master 3", gnt, 8'h08);
        drive(8'h18, 1'b1, 1'b0);
        step();
        check("R4 release master 3", gnt, 8'h00);
        drive(8'h18, 1'b0, 1'b0);
        step();
        check("R10 grant with data pending", gnt, 8'h10);
        drive(8'h00, 1'b1, 1'b1);
        step();
        drive(8'h00, 1'b0, 1'b1);
        step();
        check("R5 idle after pipelined run", gnt, 8'h00);

        // R6: park on last (master 4); R1 config takes effect one edge later.
        drive(8'h00, 1'b0, 1'b0);
        cfg_write(1'b0, 2'b10, '0);
        check("R1 config not yet active", gnt, 8'h00);
        step();
        check("R6 park on last master", gnt, 8'h10);

        // R8: parked master 4 wins over rotating winner 3 without a gap.
        drive(8'h18, 1'b0, 1'b0);
        step();
        check("R8 parked master keeps bus", gnt, 8'h10);
        step();
        check("R8 parked master holds tenure", gnt, 8'h10);
        drive(8'h08, 1'b1, 1'b0);
        step();
        check("R4 release parked owner", gnt, 8'h00);
        drive(8'h08, 1'b0, 1'b0);
        step();
        check("R3 next winner 3", gnt, 8'h08);
        drive(8'h00, 1'b1, 1'b1);
        step();
        drive(8'h00, 1'b0, 1'b0);
        step();
        check("R6 park follows new last master", gnt, 8'h08);

        // R8: parked master requesting with tenure end in the same cycle.
        drive(8'h08, 1'b1, 1'b0);
        step();
        check("R8 immediate tenure end", gnt, 8'h00);
        drive(8'h00, 1'b0, 1'b0);
        step();
        check("R6 re-park after immediate tenure", gnt, 8'h08);

        // R7: programmed parking, then change of selected master.
        cfg_write(1'b0, 2'b11, 3'd6);
        step();
        check("R7 park on master 6", gnt, 8'h40);
        cfg_write(1'b0, 2'b11, 3'd2);
        check("R7 old select still active", gnt, 8'h40);
        step();
        check("R7 park on master 2", gnt, 8'h04);

        // R5: reserved mode behaves as no parking.
        cfg_write(1'b0, 2'b01, 3'd5);
        step();
        check("R5 reserved mode no park", gnt, 8'h00);

        // R3: full rotation with all masters requesting, last was 3.
        for (int i = 0; i < N; i++) begin
            drive(8'hFF, 1'b0, 1'b0);
            step();
            check($sformatf("R3 rotation step %0d", i), gnt, N'(1) << ((4 + i) % N));
            drive(8'hFF, 1'b1, 1'b1);
            step();
            check($sformatf("R4 rotation release %0d", i), gnt, 8'h00);
        end
        drive('0, 1'b0, 1'b0);
        step();

        // R6 without history, R3 start at master 0, R9 blocks parking.
        do_reset();
        check("R1 reset grant again", gnt, 8'h00);
        cfg_write(1'b1, 2'b10, '0);
        step();
        check("R6 no history no park", gnt, 8'h00);
        drive(8'h81, 1'b0, 1'b0);
        step();
        check("R3 reset priority master 0", gnt, 8'h01);
        drive(8'h00, 1'b1, 1'b0);
        step();
        check("R4 release master 0", gnt, 8'h00);
        drive(8'h00, 1'b0, 1'b0);
        step();
        check("R9 no park while data pending", gnt, 8'h00);
        drive(8'h00, 1'b0, 1'b1);
        step();
        check("R9 park after data done", gnt, 8'h01);
        drive('0, 1'b0, 1'b0);
        step();

        summary();
    end

endmodule